// File: doc/BRIEF.md
# Mask-Selectable Coincidence Trigger Unit

This block turns comparator hits from four analog channels and one external input into a single trigger pulse for the acquisition logic. A 16-bit source word chooses which inputs take part. Its low group of bits builds an "any of" term, and its upper group builds an "all of" coincidence term. The trigger condition is true when either term is true. All hits are active high, with one polarity shared by every input. No input can be inverted on its own.

Software programs the source word, a global enable and a delay through a small register write port. Each rising edge of the combined condition starts one event. The pulse is issued after the programmed number of delay ticks, and one tick is one clock period. While a delay is counting, new events are dropped. The software side converts nanoseconds into ticks before it writes the delay register.

Top module: `trig_coinc_unit`

## Requirements
- R1: Source bits 0, 1, 2 and 3 put CH1, CH2, CH3 and CH4 (`hit_ch[0..3]`) into the any-of term, and bit 4 puts `hit_ext` into it. The condition is true when any selected input is high.
- R2: Source bits 8, 9, 10 and 11 put CH1 to CH4 into the all-of term, and bit 12 puts EXT into it. That term is true only when every selected input is high and at least one input is selected, so an empty set is false. The condition is the OR of the two terms.
- R3: Source bits 5 to 7 and 13 to 15 have no effect on the trigger.
- R4: While the enable bit (bit 0 at address 1) is 0, a new event produces no trigger.
- R5: A condition that stays true produces exactly one trigger. A new trigger needs the condition to fall and rise again.
- R6: With a delay of 0, `trig_out` is high for exactly one cycle. That cycle starts at the clock edge that first samples the condition true.
- R7: With a delay of D greater than 0, the one-cycle pulse begins D cycles later than in R6. This holds up to the largest value the delay register can hold.
- R8: A rising condition while a delay is still counting, including in its last cycle, is ignored and produces no pulse.
- R9: After reset, `trig_out` is 0, the source word is 0, enable is 0 and the delay is 0.
- R10: The register map is: address 0 is the source word, address 1 is the enable, and address 2 is the delay, taken from the low DLY_W data bits. Address 3 changes nothing. A write takes effect from the next clock edge.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one delay tick |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| hit_ch | input | 4 | Discriminator hits for CH1..CH4, bit 0 is CH1 |
| hit_ext | input | 1 | External trigger input |
| trig_out | output | 1 | Delayed one-cycle trigger pulse |

## Verification
The assertions assume that the hit inputs are already synchronous to `clk` and change only between edges. They also assume that a delay-register write does not land while a countdown is running, because the counter keeps the value it loaded. The bench changes hits and register values only on falling edges. Before each delay test it waits until the previous countdown has finished, and it sweeps every hit pattern against every any-of mask and every all-of mask.

// File: rtl/trig_coinc_pkg.sv
package trig_coinc_pkg;
    localparam int NUM_SRC    = 5;   // four channels plus external
    localparam int OR_LSB     = 0;   // any-of group position in the source word
    localparam int AND_LSB    = 8;   // all-of group position in the source word
    localparam int CFG_DATA_W = 16;
    localparam int CFG_ADDR_W = 2;

    typedef enum logic [CFG_ADDR_W-1:0] {
        ADDR_SRC = 2'd0,
        ADDR_EN  = 2'd1,
        ADDR_DLY = 2'd2
    } cfg_addr_e;
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
    import trig_coinc_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [CFG_ADDR_W-1:0] addr,
    input  logic [CFG_DATA_W-1:0] wdata,
    output logic [NUM_SRC-1:0]    or_sel,
    output logic [NUM_SRC-1:0]    and_sel,
    output logic                  en,
    output logic [DLY_W-1:0]      dly
);
    typedef struct packed {
        logic [NUM_SRC-1:0] or_sel;
        logic [NUM_SRC-1:0] and_sel;
        logic               en;
        logic [DLY_W-1:0]   dly;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // wdata bits outside the decoded fields are dropped on purpose
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (cfg_addr_e'(addr))
                ADDR_SRC: begin
                    cfg_d.or_sel  = wdata[OR_LSB  +: NUM_SRC];
                    cfg_d.and_sel = wdata[AND_LSB +: NUM_SRC];
                end
                ADDR_EN:  cfg_d.en  = wdata[0];
                ADDR_DLY: cfg_d.dly = wdata[DLY_W-1:0];
                default:  cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign or_sel  = cfg_q.or_sel;
    assign and_sel = cfg_q.and_sel;
    assign en      = cfg_q.en;
    assign dly     = cfg_q.dly;
endmodule

// File: rtl/trig_src_combine.sv
module trig_src_combine
    import trig_coinc_pkg::*;
(
    input  logic [NUM_SRC-1:0] hits,
    input  logic [NUM_SRC-1:0] or_sel,
    input  logic [NUM_SRC-1:0] and_sel,
    output logic               cond
);
    logic any_term;
    logic all_term;

    always_comb begin
        any_term = |(hits & or_sel);
        // an unselected input counts as satisfied; an empty set never matches
        all_term = (|and_sel) && (&(hits | ~and_sel));
        cond     = any_term | all_term;
    end
endmodule

// File: rtl/trig_delay_line.sv
module trig_delay_line #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cond,
    input  logic             en,
    input  logic [DLY_W-1:0] dly,
    output logic [DLY_W-1:0] cnt,
    output logic             pulse
);
    typedef struct packed {
        logic             cond_prev;
        logic [DLY_W-1:0] cnt;
        logic             pulse;
    } dl_t;

    dl_t st_d, st_q;
    logic fire;

    always_comb begin
        st_d           = st_q;
        st_d.cond_prev = cond;
        st_d.pulse     = 1'b0;
        fire           = en && cond && !st_q.cond_prev;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == DLY_W'(1)) st_d.pulse = 1'b1;
        end else if (fire) begin
            if (dly == '0) st_d.pulse = 1'b1;
            else           st_d.cnt   = dly;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt   = st_q.cnt;
    assign pulse = st_q.pulse;
endmodule

// File: rtl/trig_coinc_unit.sv
module trig_coinc_unit
    import trig_coinc_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [CFG_DATA_W-1:0] cfg_wdata,
    input  logic [3:0]            hit_ch,
    input  logic                  hit_ext,
    output logic                  trig_out
);
    logic [NUM_SRC-1:0] or_sel;
    logic [NUM_SRC-1:0] and_sel;
    logic               en_q;
    logic [DLY_W-1:0]   dly_q;
    logic [DLY_W-1:0]   cnt_q;
    logic               cond;
    logic [NUM_SRC-1:0] hits;

    assign hits = {hit_ext, hit_ch};

    trig_cfg_regs #(.DLY_W(DLY_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .or_sel(or_sel), .and_sel(and_sel), .en(en_q), .dly(dly_q)
    );

    trig_src_combine u_comb (
        .hits(hits), .or_sel(or_sel), .and_sel(and_sel), .cond(cond)
    );

    trig_delay_line #(.DLY_W(DLY_W)) u_dly (
        .clk(clk), .rst_n(rst_n), .cond(cond), .en(en_q), .dly(dly_q),
        .cnt(cnt_q), .pulse(trig_out)
    );
endmodule

// File: rtl/trig_coinc_chk.sv
module trig_coinc_chk #(
    parameter int DLY_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_q,
    input logic             cond,
    input logic [DLY_W-1:0] dly_q,
    input logic [DLY_W-1:0] cnt_q,
    input logic             trig_out
);
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> !trig_out);

    assert_immediate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && cond && !$past(cond) && cnt_q == '0 && dly_q == '0) |=> trig_out);

    assert_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > DLY_W'(1)) |=> (cnt_q == $past(cnt_q) - DLY_W'(1)));

    assert_expire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == DLY_W'(1)) |=> trig_out);

    assert_busy_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > DLY_W'(1)) |=> !trig_out);

    assert_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && cnt_q == '0) |=> !trig_out);
endmodule

bind trig_coinc_unit trig_coinc_chk #(.DLY_W(DLY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .cond(cond),
    .dly_q(dly_q), .cnt_q(cnt_q), .trig_out(trig_out)
);

// File: tb/trig_coinc_unit_tb.sv
module trig_coinc_unit_tb;
    localparam int DLY_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [3:0]  hit_ch = '0;
    logic        hit_ext = 1'b0;
    logic        trig_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    trig_coinc_unit #(.DLY_W(DLY_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hit_ch(hit_ch), .hit_ext(hit_ext), .trig_out(trig_out)
    );

    function automatic bit model(input logic [15:0] src, input logic [4:0] h);
        logic [4:0] am;
        am = src[12:8];
        return (|(src[4:0] & h)) || ((am != 0) && ((h & am) == am));
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: trig_out=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic [4:0] p);
        {hit_ext, hit_ch} = p;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        drive(5'h00);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    // zero then pattern; look just after the edge that samples the pattern
    task automatic pulse_check(input string req, input logic [4:0] p, input logic exp);
        @(negedge clk); drive(5'h00);
        @(negedge clk); drive(p);
        @(negedge clk); check(req, trig_out, exp);
    endtask

    task automatic delay_check(input string req, input int d);
        @(negedge clk); drive(5'h00);
        @(negedge clk); drive(5'h01);
        for (int k = 0; k <= d; k++) begin
            @(negedge clk); check(req, trig_out, k == d);
        end
        drive(5'h00);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); check(req, trig_out, 1'b0);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, trig_out=%0b expected completion", trig_out);
            summary();
            $finish;
        end
    end

    initial begin
        // R9: reset state, hits active throughout
        drive(5'h1F);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); check("R9 reset idle", trig_out, 1'b0);
            drive(k[0] ? 5'h1F : 5'h00);
        end
        wr(2'd1, 16'h0001);
        pulse_check("R9 empty source after reset", 5'h1F, 1'b0);

        // R1: every any-of mask against every hit pattern
        for (int m = 0; m < 32; m++) begin
            wr(2'd0, 16'(m));
            for (int p = 0; p < 32; p++)
                pulse_check("R1 any-of", 5'(p), model(16'(m), 5'(p)));
        end

        // R2: every all-of mask against every hit pattern
        for (int m = 0; m < 32; m++) begin
            wr(2'd0, 16'(m) << 8);
            for (int p = 0; p < 32; p++)
                pulse_check("R2 all-of", 5'(p), model(16'(m) << 8, 5'(p)));
        end

        // R2: mixed groups
        for (int m = 0; m < 4; m++) begin
            logic [15:0] s;
            s = (m == 0) ? 16'h0304 : (m == 1) ? 16'h1810 : (m == 2) ? 16'h0F01 : 16'h1F1F;
            wr(2'd0, s);
            for (int p = 0; p < 32; p++)
                pulse_check("R2 mixed", 5'(p), model(s, 5'(p)));
        end

        // R3: unused source bits
        wr(2'd0, 16'hE0E0);
        for (int p = 0; p < 32; p++) pulse_check("R3 unused bits only", 5'(p), 1'b0);
        wr(2'd0, 16'hE0E1);
        for (int p = 0; p < 32; p++) pulse_check("R3 unused bits plus CH1", 5'(p), p[0]);

        // R10: address 3 leaves source and enable intact
        wr(2'd0, 16'h0001);
        wr(2'd3, 16'hFFFF);
        pulse_check("R10 addr3 ignored src", 5'h02, 1'b0);
        pulse_check("R10 addr3 ignored en", 5'h01, 1'b1);

        // R4: enable
        wr(2'd0, 16'h001F);
        wr(2'd1, 16'h0000);
        for (int p = 0; p < 32; p++) pulse_check("R4 disabled", 5'(p), 1'b0);
        wr(2'd1, 16'hFFFE);
        pulse_check("R4 enable bit0 clear", 5'h01, 1'b0);
        wr(2'd1, 16'h0001);
        pulse_check("R4 re-enabled", 5'h01, 1'b1);

        // R5: held condition gives one pulse
        wr(2'd0, 16'h0001);
        @(negedge clk); drive(5'h00);
        @(negedge clk); drive(5'h01);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); check("R5 one pulse per event", trig_out, k == 0);
            drive(k[0] ? 5'h01 : 5'h03);
        end

        // R6 / R7: delays
        delay_check("R6 zero delay", 0);
        wr(2'd2, 16'd1);   delay_check("R7 delay 1", 1);
        wr(2'd2, 16'd5);   delay_check("R7 delay 5", 5);
        wr(2'd2, 16'hFF03); delay_check("R10 delay low bits", 3);
        wr(2'd2, 16'd255); delay_check("R7 delay max", 255);

        // R8: retriggers during a countdown, including its last cycle
        wr(2'd2, 16'd6);
        @(negedge clk); drive(5'h00);
        @(negedge clk); drive(5'h01);
        for (int k = 0; k <= 6; k++) begin
            @(negedge clk); check("R8 busy ignore", trig_out, k == 6);
            drive((k < 6 && k[0]) ? 5'h01 : 5'h00);
        end
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); check("R8 no late pulse", trig_out, 1'b0);
        end
        delay_check("R8 recovers", 6);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule